// File: doc/BRIEF.md
# Scalar-to-Vector Register Move Merge Unit

This block forms the result of a 32- or 64-bit scalar move between a scalar source (general register or memory) and a SIMD register. For a move into a register, it takes the scalar and the old register contents. It then builds the new register image.

The destination is either a 64-bit multimedia register or a 512-bit vector register. For vector destinations, two merge policies exist:

- **Legacy policy:** clears the bits only up to bit 127 and keeps the lanes above it.
- **Zeroing policy:** clears every bit above the moved element.

For a move out of a register, the block takes the low 32 or 64 bits of the register. It returns them as a 64-bit scalar, zero-extended when the move is 32 bits wide.

All results are registered once. A single valid pulse one cycle after the request goes with them. That pulse is split into a register write enable and a scalar valid according to direction. Instruction decoding, fault checks and register storage belong to the surrounding pipeline. A multimedia register is carried in bits 63:0 of the 512-bit register buses.

Top module: `vmov_merge_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `reg_we` and `scalar_valid` are 0 after that edge.
- R2: `out_valid` in the cycle after an edge equals `in_valid` sampled at that edge.
- R3: `reg_we` is 1 exactly for an accepted request with `dir_from_reg`=0, and `scalar_valid` is 1 exactly for an accepted request with `dir_from_reg`=1. The two are never high together.
- R4: A 32-bit move (`is_qword`=0) into a multimedia register (`is_vector`=0) gives `reg_value[31:0]` = source bits 31:0 and zeros in bits 511:32. Source bits 63:32 and `zero_upper` have no effect.
- R5: A 64-bit move (`is_qword`=1) into a multimedia register gives `reg_value[63:0]` = source and zeros in bits 511:64, whatever `zero_upper` is.
- R6: A 32-bit move into a vector register (`is_vector`=1) with `zero_upper`=0 gives source bits 31:0 in bits 31:0, zeros in bits 127:32, and old register bits 511:128 unchanged.
- R7: A 64-bit move into a vector register with `zero_upper`=0 gives the source in bits 63:0, zeros in bits 127:64, and old bits 511:128 unchanged.
- R8: A move into a vector register with `zero_upper`=1 places the 32- or 64-bit element in the low bits and clears every bit above it up to bit 511.
- R9: A 32-bit move out of a register gives `scalar_out[31:0]` = old register bits 31:0 and `scalar_out[63:32]` = 0.
- R10: A 64-bit move out of a register gives `scalar_out` = old register bits 63:0. Bits above 63 of the old register have no effect.
- R11: `reg_value` changes only after an accepted move into a register, and `scalar_out` changes only after an accepted move out. Otherwise each holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| dir_from_reg | input | 1 | 0: scalar into register, 1: register out to scalar |
| is_vector | input | 1 | 0: 64-bit multimedia register, 1: 512-bit vector register |
| is_qword | input | 1 | 0: 32-bit element, 1: 64-bit element |
| zero_upper | input | 1 | Vector merge policy, 0: keep bits above 127, 1: clear all above element |
| src_scalar | input | 64 | Scalar source for moves into a register |
| old_reg | input | 512 | Current register contents |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| reg_we | output | 1 | Write enable for the new register image |
| reg_value | output | 512 | New register image |
| scalar_valid | output | 1 | Extracted scalar is valid |
| scalar_out | output | 64 | Extracted scalar |

## Verification
Every result of this block passes through exactly one register. That covers the valid pulse, the write enable or scalar valid, and the merged register image or extracted scalar. All of them are due in the cycle right after the edge that sampled the request. The bench drives requests on falling edges and updates its own model on the rising edge that the design samples. It compares all five outputs on the next falling edge, every cycle. On idle cycles and moves in the opposite direction, the model carries the last image and scalar forward. This lets hold behaviour be checked in the same cycle-exact way.

// File: rtl/vmov_pkg.sv
package vmov_pkg;

    localparam int VREG_W_DEF = 512;
    localparam int KEEP_W_DEF = 128;
    localparam int SCL_W      = 64;
    localparam int HALF_W     = 32;
    localparam int LANE_W     = 64;

    typedef enum logic {
        DIR_TO_REG   = 1'b0,
        DIR_FROM_REG = 1'b1
    } dir_e;

    typedef enum logic {
        RC_MMX = 1'b0,
        RC_VEC = 1'b1
    } rclass_e;

    typedef enum logic {
        SZ_32 = 1'b0,
        SZ_64 = 1'b1
    } esize_e;

    typedef enum logic {
        POL_KEEP_HIGH = 1'b0,
        POL_ZERO_ALL  = 1'b1
    } policy_e;

    typedef enum logic [1:0] {
        LSEL_ELEM = 2'd0,
        LSEL_ZERO = 2'd1,
        LSEL_KEEP = 2'd2
    } lane_sel_e;

    typedef struct packed {
        dir_e    dir;
        rclass_e rclass;
        esize_e  size;
        policy_e policy;
    } mv_op_t;

    // Chooses what a 64-bit lane of the new register image holds.
    function automatic lane_sel_e lane_select(input int lane, input int keep_lanes,
                                              input rclass_e rc, input policy_e pol);
        lane_sel_e sel;
        if (lane == 0)
            sel = LSEL_ELEM;
        else if (rc == RC_MMX)
            sel = LSEL_ZERO;
        else if (lane < keep_lanes)
            sel = LSEL_ZERO;
        else if (pol == POL_KEEP_HIGH)
            sel = LSEL_KEEP;
        else
            sel = LSEL_ZERO;
        return sel;
    endfunction

    // Low lane contents: the element, zero-extended when 32 bits wide.
    function automatic logic [LANE_W-1:0] size_element(input logic [SCL_W-1:0] v,
                                                       input esize_e sz);
        logic [LANE_W-1:0] r;
        if (sz == SZ_64)
            r = v;
        else
            r = {{(LANE_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/vmov_insert.sv
module vmov_insert
    import vmov_pkg::*;
#(
    parameter int VREG_W = VREG_W_DEF,
    parameter int KEEP_W = KEEP_W_DEF
) (
    input  rclass_e           rclass,
    input  esize_e            size,
    input  policy_e           policy,
    input  logic [SCL_W-1:0]  src,
    input  logic [VREG_W-1:0] old_val,
    output logic [VREG_W-1:0] new_val
);

    localparam int LANES      = VREG_W / LANE_W;
    localparam int KEEP_LANES = KEEP_W / LANE_W;

    logic [LANE_W-1:0] elem;

    assign elem = size_element(src, size);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_sel_e sel;
        assign sel = lane_select(g, KEEP_LANES, rclass, policy);
        always_comb begin
            unique case (sel)
                LSEL_ELEM: new_val[g*LANE_W +: LANE_W] = elem;
                LSEL_KEEP: new_val[g*LANE_W +: LANE_W] = old_val[g*LANE_W +: LANE_W];
                default:   new_val[g*LANE_W +: LANE_W] = '0;
            endcase
        end
    end

endmodule

// File: rtl/vmov_extract.sv
module vmov_extract
    import vmov_pkg::*;
(
    input  esize_e            size,
    input  logic [LANE_W-1:0] low_lane,
    output logic [SCL_W-1:0]  scl
);

    assign scl = size_element(low_lane, size);

endmodule

// File: rtl/vmov_outreg.sv
module vmov_outreg
    import vmov_pkg::*;
#(
    parameter int VREG_W = VREG_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  dir_e              dir,
    input  logic [VREG_W-1:0] nxt_reg,
    input  logic [SCL_W-1:0]  nxt_scl,
    output logic              out_valid,
    output logic              reg_we,
    output logic              scalar_valid,
    output logic [VREG_W-1:0] reg_value,
    output logic [SCL_W-1:0]  scalar_out
);

    logic take_into;
    logic take_out;

    assign take_into = in_valid && (dir == DIR_TO_REG);
    assign take_out  = in_valid && (dir == DIR_FROM_REG);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            reg_we       <= 1'b0;
            scalar_valid <= 1'b0;
            reg_value    <= '0;
            scalar_out   <= '0;
        end else begin
            out_valid    <= in_valid;
            reg_we       <= take_into;
            scalar_valid <= take_out;
            if (take_into)
                reg_value <= nxt_reg;
            if (take_out)
                scalar_out <= nxt_scl;
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_no_extra_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && scalar_valid));
    p_we_into_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dir == DIR_TO_REG) |=> (reg_we && !scalar_valid));
    p_sv_out_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dir == DIR_FROM_REG) |=> (scalar_valid && !reg_we));
    p_hold_reg_r11: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && dir == DIR_TO_REG) |=> $stable(reg_value));
    p_hold_scl_r11: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && dir == DIR_FROM_REG) |=> $stable(scalar_out));

endmodule

// File: rtl/vmov_merge_unit.sv
module vmov_merge_unit
    import vmov_pkg::*;
#(
    parameter int VREG_W = VREG_W_DEF,
    parameter int KEEP_W = KEEP_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              dir_from_reg,
    input  logic              is_vector,
    input  logic              is_qword,
    input  logic              zero_upper,
    input  logic [63:0]       src_scalar,
    input  logic [VREG_W-1:0] old_reg,
    output logic              out_valid,
    output logic              reg_we,
    output logic [VREG_W-1:0] reg_value,
    output logic              scalar_valid,
    output logic [63:0]       scalar_out
);

    mv_op_t            op;
    logic [VREG_W-1:0] merged;
    logic [SCL_W-1:0]  extracted;

    assign op.dir    = dir_e'(dir_from_reg);
    assign op.rclass = rclass_e'(is_vector);
    assign op.size   = esize_e'(is_qword);
    assign op.policy = policy_e'(zero_upper);

    vmov_insert #(.VREG_W(VREG_W), .KEEP_W(KEEP_W)) u_insert (
        .rclass  (op.rclass),
        .size    (op.size),
        .policy  (op.policy),
        .src     (src_scalar),
        .old_val (old_reg),
        .new_val (merged)
    );

    vmov_extract u_extract (
        .size     (op.size),
        .low_lane (old_reg[LANE_W-1:0]),
        .scl      (extracted)
    );

    vmov_outreg #(.VREG_W(VREG_W)) u_outreg (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .dir          (op.dir),
        .nxt_reg      (merged),
        .nxt_scl      (extracted),
        .out_valid    (out_valid),
        .reg_we       (reg_we),
        .scalar_valid (scalar_valid),
        .reg_value    (reg_value),
        .scalar_out   (scalar_out)
    );

    p_mmx_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dir_from_reg && !is_vector && !is_qword) |=>
        (reg_value[VREG_W-1:32] == '0 && reg_value[31:0] == $past(src_scalar[31:0])));
    p_legacy_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dir_from_reg && is_vector && !zero_upper) |=>
        (reg_value[VREG_W-1:KEEP_W] == $past(old_reg[VREG_W-1:KEEP_W])
         && reg_value[KEEP_W-1:64] == '0));
    p_zero_above_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dir_from_reg && is_vector && zero_upper) |=>
        (reg_value[VREG_W-1:64] == '0));
    p_scalar_ext_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dir_from_reg && !is_qword) |=>
        (scalar_out[63:32] == 32'h0 && scalar_out[31:0] == $past(old_reg[31:0])));
    p_scalar_q_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dir_from_reg && is_qword) |=>
        (scalar_out == $past(old_reg[63:0])));

endmodule

// File: tb/tb_vmov_merge_unit.sv
module tb_vmov_merge_unit;

    localparam int CLK_PERIOD = 10;
    localparam int VW = 512;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          dir_from_reg = 1'b0;
    logic          is_vector = 1'b0;
    logic          is_qword = 1'b0;
    logic          zero_upper = 1'b0;
    logic [63:0]   src_scalar = '0;
    logic [VW-1:0] old_reg = '0;
    logic          out_valid, reg_we, scalar_valid;
    logic [VW-1:0] reg_value;
    logic [63:0]   scalar_out;

    int checks = 0;
    int failures = 0;
    bit armed = 1'b0;

    logic          e_ov = 1'b0, e_we = 1'b0, e_sv = 1'b0;
    logic [VW-1:0] e_reg = '0;
    logic [63:0]   e_scl = '0;
    string         tag_reg = "R11";
    string         tag_scl = "R11";

    always #(CLK_PERIOD/2) clk = ~clk;

    vmov_merge_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dir_from_reg(dir_from_reg),
        .is_vector(is_vector), .is_qword(is_qword), .zero_upper(zero_upper),
        .src_scalar(src_scalar), .old_reg(old_reg), .out_valid(out_valid),
        .reg_we(reg_we), .reg_value(reg_value), .scalar_valid(scalar_valid),
        .scalar_out(scalar_out)
    );

    task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: bit-by-bit rules from the requirements.
    always @(posedge clk) begin
        if (rst) begin
            e_ov = 0; e_we = 0; e_sv = 0; e_reg = '0; e_scl = '0;
        end else begin
            e_ov = in_valid;
            e_we = in_valid && !dir_from_reg;
            e_sv = in_valid && dir_from_reg;
            tag_reg = "R11";
            tag_scl = "R11";
            if (in_valid && !dir_from_reg) begin
                for (int i = 0; i < VW; i++) begin
                    if (i < 32)                    e_reg[i] = src_scalar[i];
                    else if (i < 64)               e_reg[i] = is_qword ? src_scalar[i] : 1'b0;
                    else if (!is_vector)           e_reg[i] = 1'b0;
                    else if (i < 128)              e_reg[i] = 1'b0;
                    else                           e_reg[i] = zero_upper ? 1'b0 : old_reg[i];
                end
                if (!is_vector)       tag_reg = is_qword ? "R5" : "R4";
                else if (zero_upper)  tag_reg = "R8";
                else                  tag_reg = is_qword ? "R7" : "R6";
            end
            if (in_valid && dir_from_reg) begin
                for (int i = 0; i < 64; i++)
                    e_scl[i] = (i < 32 || is_qword) ? old_reg[i] : 1'b0;
                tag_scl = is_qword ? "R10" : "R9";
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk("R2", VW'(out_valid), VW'(e_ov));
            chk("R3", VW'(reg_we), VW'(e_we));
            chk("R3", VW'(scalar_valid), VW'(e_sv));
            chk(tag_reg, reg_value, e_reg);
            chk(tag_scl, VW'(scalar_out), VW'(e_scl));
        end
    end

    function automatic logic [VW-1:0] rnd_wide();
        logic [VW-1:0] r;
        for (int k = 0; k < VW/32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic issue(input bit v, input bit d, input bit vec, input bit q, input bit z,
                         input logic [63:0] s, input logic [VW-1:0] o);
        @(negedge clk);
        in_valid = v; dir_from_reg = d; is_vector = vec; is_qword = q; zero_upper = z;
        src_scalar = s; old_reg = o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [VW-1:0] ones;
        ones = '1;
        repeat (3) @(negedge clk);
        chk("R1", VW'(out_valid), '0);
        chk("R1", VW'(reg_we), '0);
        chk("R1", VW'(scalar_valid), '0);
        rst = 1'b0;
        armed = 1'b1;
        // Directed corners (R4..R10), idle gaps (R11)
        issue(1, 0, 0, 0, 1, 64'hDEAD_BEEF_1234_5678, ones);  // R4
        issue(1, 0, 0, 1, 0, 64'hCAFE_F00D_8765_4321, ones);  // R5
        issue(0, 0, 0, 0, 0, '0, '0);                        // R11
        issue(1, 0, 1, 0, 0, 64'hFFFF_FFFF_0000_0001, ones);  // R6
        issue(1, 0, 1, 1, 0, 64'h0123_4567_89AB_CDEF, ones);  // R7
        issue(1, 0, 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, ones);  // R8
        issue(1, 0, 1, 1, 1, 64'hA5A5_A5A5_5A5A_5A5A, ones);  // R8
        issue(1, 1, 1, 0, 0, '1, ones);                       // R9
        issue(1, 1, 0, 1, 1, '0, ones);                       // R10
        issue(1, 1, 1, 1, 0, '0, {ones[VW-1:64], 64'h0});     // R10 upper ignored
        issue(0, 1, 0, 0, 0, '1, ones);                       // R11
        for (int n = 0; n < 400; n++) begin
            issue(($urandom % 4) != 0, $urandom, $urandom, $urandom, $urandom,
                  {$urandom, $urandom}, rnd_wide());
        end
        issue(0, 0, 0, 0, 0, '0, '0);
        repeat (2) @(negedge clk);
        armed = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule